// File: doc/BRIEF.md
# Byte-Mapped BCD Real-Time Clock

This block is a real-time clock whose time-of-day registers sit at the top of a byte-wide memory map, beside a small general-purpose RAM. The seven time bytes (second, minute, hour, weekday, day of month, month, year) are plain read/write cells kept in BCD. An internal set of counters advances on every pulse of a one-per-second tick input. The counters handle 24-hour time, month lengths and leap years for a two-digit year. While updates are enabled, each tick copies the newly advanced count into the visible bytes.

Software reaches everything over a synchronous byte bus with active-low chip enable, output enable and write enable. A control byte just below the time bytes holds two gating bits and a six-bit calibration field. One bit suspends updates so that new time values can be loaded. The other freezes the visible bytes to give a consistent snapshot while counting goes on internally. A power-fail input blocks every write while it is high, and timekeeping carries on.

The gating is an update-control state machine with four states. ST_RUN lets ticks refresh the visible bytes. ST_FREEZE holds the bytes while the control read bit is set. ST_HALT holds the bytes while the control write bit is set. ST_LOAD lasts one cycle after the write bit clears and copies the visible bytes into the counters. The transitions are:
- RUN→HALT when the write bit is set.
- RUN→FREEZE when only the read bit is set.
- FREEZE→HALT when the write bit is set.
- FREEZE→RUN when the read bit clears.
- HALT→LOAD when the write bit clears.
- LOAD leaves in one cycle: to HALT if the write bit is set, otherwise to FREEZE if the read bit is set, otherwise to RUN.

Top module: `rtc_nvram_top`

## Requirements
- R1: The address map places the control byte at 1FF8h and the time bytes from 1FF9h to 1FFFh in the order second, minute, hour, weekday, day of month, month, year. RAM bytes sit at addresses 0 to RAM_DEPTH-1 (16 by default). Any other address reads 00h and ignores writes. After reset the time is 00:00:00, the weekday is 01, the date is 01/01/00 and the control byte is 00h.
- R2: A read is chip enable low, write enable high and output enable low. Its data appears on dout with dout_vld high in the cycle after it is sampled. A write is chip enable and write enable both low, whatever output enable is. dout_vld is low after any cycle that was not a read, including every cycle with chip enable high.
- R3: Seconds and minutes count in BCD and roll from 59 to 00. Hours roll from 23 to 00, with each carry passed to the next field.
- R4: The weekday advances at midnight and runs 01 to 07, wrapping from 07 to 01.
- R5: The day of month rolls to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02. Month 12 rolls to 01 and advances the year, and year 99 rolls to 00.
- R6: February ends after day 28, or after day 29 when the two-digit BCD year is divisible by 4.
- R7: The time bytes are ordinary read/write cells. In ST_RUN, a value written to one of them reads back until the next tick overwrites all seven bytes with the newly advanced count.
- R8: While control bit 7 is set, ticks do not change the visible bytes. Clearing the bit loads the visible bytes into the counters within two cycles, and later ticks count on from the loaded time.
- R9: While control bit 6 is set, the visible bytes hold still and the counters keep advancing. The first tick after the bit clears shows the count including every tick that arrived during the freeze.
- R10: Control bits 5:0 are stored and read back unchanged, and they have no effect on timekeeping.
- R11: While pwr_fail is high, writes to RAM, time bytes and the control byte are ignored, while ticks are still counted and shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered |
| dout_vld | output | 1 | Read data valid (low models a high-impedance bus) |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| pwr_fail | input | 1 | Supply out of tolerance; blocks all writes |

## Verification
A counter that carries wrongly stays hidden until the tick that crosses its boundary. It then shows up as a wrong BCD value in the next read of the affected byte, one cycle after that read. A state machine stuck in ST_HALT or ST_FREEZE shows as a time byte that fails to move on the next tick. A missed ST_LOAD pass shows on the first tick after the control write bit clears, because the bytes then jump back to the old count. A broken power-fail gate shows as a changed control or RAM byte on the first read after the blocked write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_FREEZE,
        ST_HALT,
        ST_LOAD
    } upd_state_e;

    localparam rtc_time_t RTC_RESET_TIME = '{
        year: 8'h00, month: 8'h01, mday: 8'h01, wday: 8'h01,
        hour: 8'h00, minute: 8'h00, sec: 8'h00
    };

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] yr);
        logic [6:0] ybin;
        ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t time_next(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec != 8'h59) begin
            n.sec = bcd_inc(t.sec);
        end else begin
            n.sec = 8'h00;
            if (t.minute != 8'h59) begin
                n.minute = bcd_inc(t.minute);
            end else begin
                n.minute = 8'h00;
                if (t.hour != 8'h23) begin
                    n.hour = bcd_inc(t.hour);
                end else begin
                    n.hour = 8'h00;
                    n.wday = (t.wday == 8'h07) ? 8'h01 : bcd_inc(t.wday);
                    if (t.mday != month_last_day(t.month, t.year)) begin
                        n.mday = bcd_inc(t.mday);
                    end else begin
                        n.mday = 8'h01;
                        if (t.month != 8'h12) begin
                            n.month = bcd_inc(t.month);
                        end else begin
                            n.month = 8'h01;
                            n.year  = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_time,
    output rtc_time_t cur_time,
    output rtc_time_t nxt_time
);

    rtc_time_t cnt_q;

    assign nxt_time = time_next(cnt_q);
    assign cur_time = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RTC_RESET_TIME;
        end else if (load) begin
            cnt_q <= load_time;
        end else if (tick) begin
            cnt_q <= nxt_time;
        end
    end

endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int RAM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              upd_en,
    input  rtc_time_t         upd_time,
    output rtc_time_t         vis_time,
    output logic [7:0]        ctrl,
    output logic [7:0]        rdata,
    output logic              rd_vld
);

    localparam int RAM_AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
    localparam logic [ADDR_W-1:0] CLK_BASE = ADDR_W'((1 << ADDR_W) - 8);
    localparam logic [ADDR_W-1:0] RAM_TOP  = ADDR_W'(RAM_DEPTH);

    logic [55:0] vis_q;
    logic [7:0]  ctrl_q;
    logic [7:0]  ram_q [RAM_DEPTH];
    logic        clk_hit;
    logic        ram_hit;
    logic [2:0]  slot;
    logic [2:0]  tslot;
    logic [7:0]  rd_sel;

    assign clk_hit  = (addr >= CLK_BASE);
    assign ram_hit  = (addr < RAM_TOP);
    assign slot     = addr[2:0];
    assign tslot    = slot - 3'd1;
    assign vis_time = rtc_time_t'(vis_q);
    assign ctrl     = ctrl_q;

    always_comb begin
        rd_sel = 8'h00;
        if (clk_hit) begin
            rd_sel = (slot == 3'd0) ? ctrl_q : vis_q[{tslot, 3'b000} +: 8];
        end else if (ram_hit) begin
            rd_sel = ram_q[addr[RAM_AW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q  <= RTC_RESET_TIME;
            ctrl_q <= 8'h00;
            rdata  <= 8'h00;
            rd_vld <= 1'b0;
        end else begin
            if (upd_en) begin
                vis_q <= upd_time;
            end else if (wr_en && clk_hit && slot != 3'd0) begin
                vis_q[{tslot, 3'b000} +: 8] <= wdata;
            end
            if (wr_en && clk_hit && slot == 3'd0) begin
                ctrl_q <= wdata;
            end
            rd_vld <= rd_en;
            rdata  <= rd_en ? rd_sel : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && ram_hit) begin
            ram_q[addr[RAM_AW-1:0]] <= wdata;
        end
    end

endmodule

// File: rtl/rtc_nvram_top.sv
module rtc_nvram_top
    import rtc_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int RAM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_vld,
    input  logic              tick_1hz,
    input  logic              pwr_fail
);

    localparam int WR_BIT = 7;
    localparam int RD_BIT = 6;

    upd_state_e state_q;
    upd_state_e state_nx;
    logic       rd_en;
    logic       wr_en;
    logic       upd_en;
    logic       load_en;
    logic [7:0] ctrl_w;
    rtc_time_t  vis_time;
    rtc_time_t  cur_time;
    rtc_time_t  nxt_time;

    assign rd_en = !ce_n && we_n && !oe_n;
    assign wr_en = !ce_n && !we_n && !pwr_fail;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ctrl_w[WR_BIT])      state_nx = ST_HALT;
                else if (ctrl_w[RD_BIT]) state_nx = ST_FREEZE;
            end
            ST_FREEZE: begin
                if (ctrl_w[WR_BIT])       state_nx = ST_HALT;
                else if (!ctrl_w[RD_BIT]) state_nx = ST_RUN;
            end
            ST_HALT: begin
                if (!ctrl_w[WR_BIT]) state_nx = ST_LOAD;
            end
            ST_LOAD: begin
                if (ctrl_w[WR_BIT])      state_nx = ST_HALT;
                else if (ctrl_w[RD_BIT]) state_nx = ST_FREEZE;
                else                     state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        upd_en  = (state_q == ST_RUN) && tick_1hz;
        load_en = (state_q == ST_LOAD);
    end

    rtc_time_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1hz),
        .load      (load_en),
        .load_time (vis_time),
        .cur_time  (cur_time),
        .nxt_time  (nxt_time)
    );

    rtc_byte_store #(
        .ADDR_W    (ADDR_W),
        .RAM_DEPTH (RAM_DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (din),
        .upd_en   (upd_en),
        .upd_time (nxt_time),
        .vis_time (vis_time),
        .ctrl     (ctrl_w),
        .rdata    (dout),
        .rd_vld   (dout_vld)
    );

endmodule

// File: rtl/rtc_nvram_chk.sv
module rtc_nvram_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              pwr_fail,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        din,
    input logic              dout_vld,
    input logic [7:0]        ctrl,
    input logic [55:0]       vis
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'((1 << ADDR_W) - 8);

    assert_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_vld);

    assert_read_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n) |=> dout_vld);

    assert_pwr_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> $stable(ctrl));

    assert_ctrl_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n && !pwr_fail && addr == CTRL_ADDR) |=> (ctrl == $past(din)));

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[7] && $past(ctrl[7]) && (ce_n || we_n)) |=> $stable(vis));

    assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[6] && $past(ctrl[6]) && (ce_n || we_n)) |=> $stable(vis));

endmodule

bind rtc_nvram_top rtc_nvram_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .pwr_fail (pwr_fail),
    .addr     (addr),
    .din      (din),
    .dout_vld (dout_vld),
    .ctrl     (ctrl_w),
    .vis      (vis_time)
);

// File: tb/rtc_nvram_top_tb_top.sv
`timescale 1ns/1ps
module rtc_nvram_top_tb_top;

    localparam logic [12:0] A_CTRL = 13'h1FF8;
    localparam logic [12:0] A_SEC  = 13'h1FF9;
    localparam logic [12:0] A_MIN  = 13'h1FFA;
    localparam logic [12:0] A_HR   = 13'h1FFB;
    localparam logic [12:0] A_WDAY = 13'h1FFC;
    localparam logic [12:0] A_MDAY = 13'h1FFD;
    localparam logic [12:0] A_MON  = 13'h1FFE;
    localparam logic [12:0] A_YR   = 13'h1FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_vld;
    logic        tick_1hz = 1'b0;
    logic        pwr_fail = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  exp_q  [$];
    logic [12:0] addr_q [$];
    string       tag_q  [$];

    always #2.5 clk = ~clk;

    rtc_nvram_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (din),
        .dout     (dout),
        .dout_vld (dout_vld),
        .tick_1hz (tick_1hz),
        .pwr_fail (pwr_fail)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: pops the scoreboard whenever read data is presented
    always @(negedge clk) begin
        if (rst_n && dout_vld) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected dout_vld actual=%h expected=none", dout);
            end else begin
                automatic logic [7:0]  e = exp_q.pop_front();
                automatic logic [12:0] a = addr_q.pop_front();
                automatic string       t = tag_q.pop_front();
                if (dout !== e) begin
                    n_bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, a, dout, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [12:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        addr_q.push_back(a);
        tag_q.push_back(t);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic oe);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = oe; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic chk_novld(input string t);
        @(negedge clk);
        n_cmp++;
        if (dout_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL %s dout_vld actual=%b expected=0", t, dout_vld);
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] wd, input logic [7:0] md,
                            input logic [7:0] mo, input logic [7:0] y);
        wr(A_CTRL, 8'h80, 1'b1);
        idle(2);
        wr(A_SEC, s, 1'b1);   wr(A_MIN, m, 1'b1);  wr(A_HR, h, 1'b1);
        wr(A_WDAY, wd, 1'b1); wr(A_MDAY, md, 1'b1);
        wr(A_MON, mo, 1'b1);  wr(A_YR, y, 1'b1);
        wr(A_CTRL, 8'h00, 1'b1);
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_CTRL, 8'h00, "R1 reset ctrl");
        rd(A_SEC,  8'h00, "R1 reset sec");
        rd(A_HR,   8'h00, "R1 reset hour");
        rd(A_WDAY, 8'h01, "R1 reset wday");
        rd(A_MDAY, 8'h01, "R1 reset mday");
        rd(A_MON,  8'h01, "R1 reset month");
        rd(A_YR,   8'h00, "R1 reset year");

        // R2 bus decode
        chk_novld("R2 ce_n high");
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = A_SEC;
        @(negedge clk); ce_n = 1'b1;
        n_cmp++;
        if (dout_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 oe_n high dout_vld actual=%b expected=0", dout_vld);
        end

        // R1/R2 RAM and unmapped space
        wr(13'h0003, 8'hA5, 1'b1);
        rd(13'h0003, 8'hA5, "R1 ram readback");
        wr(13'h0004, 8'h3C, 1'b0);
        rd(13'h0004, 8'h3C, "R2 write with oe_n low");
        wr(13'h0100, 8'h77, 1'b1);
        rd(13'h0100, 8'h00, "R1 unmapped reads zero");

        // R8 halt: tick while halted leaves bytes alone
        wr(A_CTRL, 8'h80, 1'b1);
        idle(2);
        wr(A_SEC, 8'h58, 1'b1);
        tick();
        rd(A_SEC, 8'h58, "R8 halted byte");
        wr(A_MIN, 8'h59, 1'b1);  wr(A_HR, 8'h23, 1'b1);
        wr(A_WDAY, 8'h07, 1'b1); wr(A_MDAY, 8'h28, 1'b1);
        wr(A_MON, 8'h02, 1'b1);  wr(A_YR, 8'h23, 1'b1);
        wr(A_CTRL, 8'h00, 1'b1);
        idle(4);
        tick();
        rd(A_SEC, 8'h59, "R8 counts from loaded time");
        tick();
        rd(A_SEC,  8'h00, "R3 sec roll");
        rd(A_MIN,  8'h00, "R3 min roll");
        rd(A_HR,   8'h00, "R3 hour roll");
        rd(A_WDAY, 8'h01, "R4 weekday wrap");
        rd(A_MDAY, 8'h01, "R6 feb non-leap end");
        rd(A_MON,  8'h03, "R6 feb to mar");
        rd(A_YR,   8'h23, "R5 year kept");

        // R6 leap year
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        tick();
        rd(A_MDAY, 8'h29, "R6 leap feb 29");
        rd(A_MON,  8'h02, "R6 leap stays feb");
        rd(A_WDAY, 8'h04, "R4 weekday step");
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
        tick();
        rd(A_MDAY, 8'h01, "R6 leap feb end");
        rd(A_MON,  8'h03, "R6 leap to mar");

        // R5 month lengths and year wrap
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25);
        tick();
        rd(A_MDAY, 8'h01, "R5 30-day month end");
        rd(A_MON,  8'h05, "R5 apr to may");
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h05, 8'h25);
        tick();
        rd(A_MDAY, 8'h31, "R5 31-day month day 31");
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        tick();
        rd(A_MDAY, 8'h01, "R5 dec end");
        rd(A_MON,  8'h01, "R5 month wrap");
        rd(A_YR,   8'h00, "R5 year wrap");

        // R3 hour carry and BCD digit carry
        set_time(8'h59, 8'h59, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00);
        tick();
        rd(A_HR,  8'h13, "R3 hour step");
        rd(A_MIN, 8'h00, "R3 min wrap");
        set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick();
        rd(A_SEC, 8'h10, "R3 bcd digit carry");

        // R9 freeze
        wr(A_CTRL, 8'h40, 1'b1);
        idle(2);
        tick(); tick(); tick();
        rd(A_SEC,  8'h10, "R9 frozen byte");
        rd(A_CTRL, 8'h40, "R9 read bit stored");
        wr(A_CTRL, 8'h00, 1'b1);
        idle(2);
        tick();
        rd(A_SEC, 8'h14, "R9 count kept during freeze");

        // R10 calibration field
        wr(A_CTRL, 8'h2A, 1'b1);
        rd(A_CTRL, 8'h2A, "R10 calibration stored");
        idle(2);
        tick();
        rd(A_SEC, 8'h15, "R10 calibration no effect");

        // R11 power fail
        pwr_fail = 1'b1;
        wr(A_CTRL, 8'h80, 1'b1);
        wr(13'h0003, 8'h5A, 1'b1);
        wr(A_MIN, 8'h33, 1'b1);
        tick();
        rd(A_SEC,     8'h16, "R11 ticks continue");
        rd(A_MIN,     8'h00, "R11 time write blocked");
        rd(A_CTRL,    8'h2A, "R11 ctrl write blocked");
        rd(13'h0003,  8'hA5, "R11 ram write blocked");
        pwr_fail = 1'b0;

        // R7 plain write to a time byte, then overwritten by a tick
        wr(A_MIN, 8'h42, 1'b1);
        rd(A_MIN, 8'h42, "R7 time byte is rw");
        tick();
        rd(A_MIN, 8'h00, "R7 tick overwrites");
        rd(A_SEC, 8'h17, "R7 tick advances");

        idle(4);
        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule